// File: doc/BRIEF.md
# Packed Pixel Serializer with Byte, Pixel and Colour Ordering

The serializer sits between a frame-data FIFO and the pixel path of a display controller. It pulls 32-bit words from the FIFO and hands them out one pixel at a time, one pixel for each request strobe. A pixel can be 1, 2, 4, 8 or 16 bits wide. A word is popped only after every pixel it holds has been sent.

Three ordering controls shape each word on its way out. The byte-order control picks how the bytes of the word are walked. The pixel-order control picks which end of a byte holds the first pixel, and it matters only when a pixel is smaller than a byte. The colour-swap control exchanges the red and blue channels of 16-bit pixels once they have been widened to 8 bits per channel. Pixels narrower than 16 bits leave as palette indices in the low bits. A panel-power enable forces the 24-bit output to zero whenever it is off.

The controls are captured in a configuration register on every clock, so a change takes effect one cycle after it is applied. The control loop has two states. S_WAIT holds no word. S_SHIFT holds a word and emits from it. FETCH (S_WAIT to S_SHIFT) pops a word when the FIFO is not empty. RELOAD stays in S_SHIFT and pops the next word in the cycle that emits the last pixel of the current one, so there is no bubble. DRAIN (S_SHIFT to S_WAIT) is taken when the last pixel leaves and the FIFO is empty. HOLD keeps the state when there is no request or no data.

Top module: `pix_serializer`

## Requirements
- R1: While reset is active and after it is released, pix_valid and pix_data are 0 and fifo_pop is low. All captured controls, power included, reset to 0.
- R2: bpp_sel selects the pixel size: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits, 4 = 16 bits (5 to 7 act as 8 bits). Each word gives 32/size pixels. fifo_pop is raised only when fifo_empty is low. It is never raised in two consecutive cycles, and a new word is popped only in the cycle that emits the last pixel of the current word (or when none is held).
- R3: byte_big = 0 walks the bytes of a word from bits [7:0] up to [31:24]. byte_big = 1 walks them from [31:24] down to [7:0]. A 16-bit pixel takes the next stream byte as its low half and the one after it as its high half.
- R4: For 1, 2 and 4 bit pixels, pix_big = 0 takes the first pixel of a byte from its least significant bits. pix_big = 1 takes it from its most significant bits. The pixel value goes out in the low bits of pix_data with the upper bits zero.
- R5: pix_big has no effect on the output in the 8-bit and 16-bit modes.
- R6: A 16-bit pixel has red in [15:11], green in [10:5] and blue in [4:0]. Each field is widened to 8 bits by copying its top bits below it. The output is red in [23:16], green in [15:8] and blue in [7:0]. An 8-bit pixel goes out in [7:0].
- R7: With rb_swap = 1 in the 16-bit mode, the widened red and blue are exchanged (blue in [23:16], red in [7:0]). rb_swap has no effect in the other modes.
- R8: While the captured power enable is 0, pix_data is all zeros. While it is 1, pix_data shows the last emitted pixel.
- R9: pix_valid rises in the cycle after a pix_req that found a word held. With pix_req low, or with no word held and the FIFO empty, no pixel is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bpp_sel | input | 3 | Pixel size code |
| byte_big | input | 1 | Byte walk order within a word |
| pix_big | input | 1 | Pixel order within a byte (sub-byte modes) |
| rb_swap | input | 1 | Swap red and blue in 16-bit mode |
| pwr_en | input | 1 | Panel power enable; 0 forces pix_data to zero |
| fifo_data | input | WORD_W | Head word of the frame FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Take the head word this cycle |
| pix_req | input | 1 | Request strobe for the next pixel |
| pix_valid | output | 1 | A new pixel is on pix_data |
| pix_data | output | 24 | Pixel value or index |

## Verification
The bench runs every pixel size with both pixel orders, so a design that mirrored the bit offset in the wrong direction, or also mirrored 8-bit or 16-bit pixels, would produce mismatched indices. Both byte orders are run in the 8-bit and 16-bit modes, where a byte walk that was not reversed would show up as swapped halves. The swap is run in the 16-bit mode and in the 8-bit mode, which catches a swap that leaks into index output. It also catches a design that widened fields by zero-filling. Random request gaps, back-to-back words, an empty-FIFO stall, a held request, and a power-off stream followed by a power-off hold catch designs that drop or repeat pixels around word edges, or that let data reach the panel while it is unpowered.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int LG_W   = 3;
    localparam int BITS_W = 5;

    typedef enum logic [2:0] {
        BPP_1  = 3'd0,
        BPP_2  = 3'd1,
        BPP_4  = 3'd2,
        BPP_8  = 3'd3,
        BPP_16 = 3'd4
    } bpp_e;

    typedef enum logic {
        S_WAIT  = 1'b0,
        S_SHIFT = 1'b1
    } state_e;

    typedef struct packed {
        logic       pwr;
        logic       swap_rb;
        logic       pix_big;
        logic       byte_big;
        logic [2:0] bpp;
    } cfg_t;

    // log2 of the pixel width in bits; undefined codes act as 8 bits
    function automatic logic [LG_W-1:0] lg_bits(input logic [2:0] code);
        return (code <= 3'(BPP_16)) ? LG_W'(code) : LG_W'(BPP_8);
    endfunction

endpackage

// File: rtl/pxs_byte_order.sv
module pxs_byte_order #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              big_i,
    output logic [WORD_W-1:0] stream_o
);
    localparam int NB = WORD_W / 8;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign stream_o[8*k +: 8] = big_i ? word_i[8*(NB-1-k) +: 8]
                                          : word_i[8*k +: 8];
    end
endmodule

// File: rtl/pxs_pixel_pick.sv
module pxs_pixel_pick
    import pxs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] stream_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [LG_W-1:0]   lg_i,
    input  logic              pix_big_i,
    output logic [15:0]       pix_o
);
    logic [BITS_W-1:0] bits;
    logic [CNT_W-1:0]  offset;
    logic [CNT_W-1:0]  flip;
    logic [CNT_W-1:0]  shift;
    logic [WORD_W-1:0] shifted;
    logic [16:0]       mask;

    always_comb begin
        bits    = BITS_W'(1) << lg_i;
        offset  = idx_i << lg_i;
        // mirroring inside a byte: offset within byte b*j becomes (8-b)-b*j
        flip    = (pix_big_i && (bits < BITS_W'(8))) ? CNT_W'(BITS_W'(8) - bits) : '0;
        shift   = offset ^ flip;
        shifted = stream_i >> shift;
        mask    = (17'd1 << bits) - 17'd1;
        pix_o   = shifted[15:0] & mask[15:0];
    end
endmodule

// File: rtl/pxs_colour_fmt.sv
module pxs_colour_fmt
    import pxs_pkg::*;
(
    input  logic [15:0]     pix_i,
    input  logic [LG_W-1:0] lg_i,
    input  logic            swap_i,
    output logic [PIX_W-1:0] pix_o
);
    logic [CH_W-1:0] red, grn, blu;

    always_comb begin
        red = {pix_i[15:11], pix_i[15:13]};
        grn = {pix_i[10:5],  pix_i[10:9]};
        blu = {pix_i[4:0],   pix_i[4:2]};
        if (lg_i == LG_W'(BPP_16)) begin
            pix_o = swap_i ? {blu, grn, red} : {red, grn, blu};
        end else begin
            pix_o = {{(PIX_W-16){1'b0}}, pix_i};
        end
    end
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
    import pxs_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bpp_sel,
    input  logic              byte_big,
    input  logic              pix_big,
    input  logic              rb_swap,
    input  logic              pwr_en,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic              pix_req,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data
);
    localparam int CNT_W = $clog2(WORD_W);

    cfg_t              cfg_q;
    state_e            state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  idx_q;
    logic [PIX_W-1:0]  data_q;
    logic              valid_q;
    logic              pop;

    logic [LG_W-1:0]   lg;
    logic [CNT_W-1:0]  last_idx;
    logic              fire;
    logic              at_last;
    logic [WORD_W-1:0] stream;
    logic [15:0]       raw_pix;
    logic [PIX_W-1:0]  fmt_pix;

    assign lg       = lg_bits(cfg_q.bpp);
    assign last_idx = CNT_W'((WORD_W >> lg) - 1);
    assign fire     = (state_q == S_SHIFT) && pix_req;
    assign at_last  = (idx_q == last_idx);

    // configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= '{pwr: pwr_en, swap_rb: rb_swap, pix_big: pix_big,
                       byte_big: byte_big, bpp: bpp_sel};
        end
    end

    // next state: FETCH, RELOAD, DRAIN, HOLD
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            S_WAIT: begin
                if (!fifo_empty) begin          // FETCH
                    pop     = 1'b1;
                    state_d = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (fire && at_last) begin
                    if (!fifo_empty) begin      // RELOAD
                        pop = 1'b1;
                    end else begin              // DRAIN
                        state_d = S_WAIT;
                    end
                end
            end
        endcase
    end

    assign fifo_pop = pop & rst_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // word holding and pixel index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (pop) begin
            word_q <= fifo_data;
            idx_q  <= '0;
        end else if (fire) begin
            idx_q  <= idx_q + CNT_W'(1);
        end
    end

    pxs_byte_order #(.WORD_W(WORD_W)) u_order (
        .word_i   (word_q),
        .big_i    (cfg_q.byte_big),
        .stream_o (stream)
    );

    pxs_pixel_pick #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_pick (
        .stream_i  (stream),
        .idx_i     (idx_q),
        .lg_i      (lg),
        .pix_big_i (cfg_q.pix_big),
        .pix_o     (raw_pix)
    );

    pxs_colour_fmt u_fmt (
        .pix_i  (raw_pix),
        .lg_i   (lg),
        .swap_i (cfg_q.swap_rb),
        .pix_o  (fmt_pix)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= fire;
            if (fire) begin
                data_q <= fmt_pix;
            end
        end
    end

    assign pix_valid = valid_q;
    assign pix_data  = cfg_q.pwr ? data_q : '0;

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_en,
    input logic          fifo_empty,
    input logic          fifo_pop,
    input logic          pix_req,
    input logic          pix_valid,
    input logic [PW-1:0] pix_data
);
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R2

    AST_POP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop); // R2

    AST_PWR_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_en) |-> (pix_data == '0)); // R8

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_req)); // R9
endmodule

bind pix_serializer pxs_checker #(.PW(pxs_pkg::PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en     (pwr_en),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .pix_req    (pix_req),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data)
);

// File: tb/pix_serializer_tb.sv
`timescale 1ns/1ps
module pix_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bpp_sel;
    logic        byte_big, pix_big, rb_swap, pwr_en;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        pix_req;
    logic        pix_valid;
    logic [23:0] pix_data;

    always #2 clk = ~clk;

    pix_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .bpp_sel(bpp_sel), .byte_big(byte_big),
        .pix_big(pix_big), .rb_swap(rb_swap), .pwr_en(pwr_en),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .pix_req(pix_req), .pix_valid(pix_valid), .pix_data(pix_data)
    );

    int          total = 0;
    int          bad   = 0;
    logic [31:0] fq[$];
    logic [23:0] exp_q[$];
    string       tag_q[$];
    int          pops_seen = 0;
    int          pops_done = 0;
    logic [23:0] last_exp = '0;
    bit          req_rand = 0;
    bit          req_off  = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // FIFO model: pops seen at a rising edge are retired at the next falling edge
    always @(posedge clk) if (rst_n && fifo_pop) pops_seen <= pops_seen + 1;

    always @(negedge clk) begin
        while (pops_done < pops_seen) begin
            if (fq.size() > 0) void'(fq.pop_front());
            pops_done++;
        end
        fifo_empty <= (fq.size() == 0);
        fifo_data  <= (fq.size() > 0) ? fq[0] : 32'h0;
        lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pix_req    <= req_off ? 1'b0 : (req_rand ? lfsr[0] : 1'b1);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 pixel with nothing expected", {8'h0, pix_data}, 32'h0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(pix_data === e, t, {8'h0, pix_data}, {8'h0, e});
            end
        end
    end

    function automatic int size_of(input logic [2:0] m);
        case (m)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd4: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] w, input int k, input bit big);
        int pos;
        pos = big ? (3 - k) : k;
        return w[8*pos +: 8];
    endfunction

    task automatic push_word(input logic [31:0] w, input string tag);
        int b;
        b = size_of(bpp_sel);
        for (int i = 0; i < 32 / b; i++) begin
            logic [23:0] e;
            int k;
            k = (i * b) / 8;
            if (b == 16) begin
                logic [15:0] p;
                logic [7:0] r, g, bl;
                p  = {byte_at(w, k + 1, byte_big), byte_at(w, k, byte_big)};
                r  = {p[15:11], p[15:13]};
                g  = {p[10:5], p[10:9]};
                bl = {p[4:0], p[4:2]};
                e  = rb_swap ? {bl, g, r} : {r, g, bl};
            end else if (b == 8) begin
                e = {16'h0, byte_at(w, k, byte_big)};
            end else begin
                int j, pos;
                logic [7:0] by;
                j   = i % (8 / b);
                pos = pix_big ? (8 - b * (j + 1)) : (b * j);
                by  = byte_at(w, k, byte_big);
                e   = {16'h0, (by >> pos) & 8'((1 << b) - 1)};
            end
            if (!pwr_en) e = '0;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        fq.push_back(w);
    endtask

    task automatic set_cfg(input logic [2:0] m, input bit bb, input bit pb, input bit sw, input bit pw);
        wait (exp_q.size() == 0 && fq.size() == 0);
        repeat (4) @(negedge clk);
        bpp_sel = m; byte_big = bb; pix_big = pb; rb_swap = sw; pwr_en = pw;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bpp_sel = 3'd0; byte_big = 0; pix_big = 0; rb_swap = 0; pwr_en = 1;
        fifo_empty = 1; fifo_data = '0; pix_req = 0;
        repeat (4) @(negedge clk);
        // R1: power input high during reset but captured power is cleared
        check(pix_valid == 0, "R1 valid in reset", {31'h0, pix_valid}, 0);
        check(pix_data == 0, "R1 data in reset", {8'h0, pix_data}, 0);
        check(fifo_pop == 0, "R1 pop in reset", {31'h0, fifo_pop}, 0);
        pwr_en = 0;
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        check(pix_valid == 0 && pix_data == 0, "R1 after reset", {8'h0, pix_data}, 0);

        set_cfg(3'd0, 0, 0, 0, 1);
        push_word(32'hA5C3_0F81, "R4 1bpp lsb-first"); push_word(32'h1234_5678, "R2 1bpp back-to-back");
        set_cfg(3'd0, 0, 1, 0, 1);
        push_word(32'hA5C3_0F81, "R4 1bpp msb-first");
        set_cfg(3'd1, 0, 0, 0, 1);
        push_word(32'h1B6C_E4D2, "R4 2bpp lsb-first");
        set_cfg(3'd1, 0, 1, 0, 1);
        push_word(32'h1B6C_E4D2, "R4 2bpp msb-first");
        set_cfg(3'd2, 1, 0, 0, 1);
        push_word(32'h0123_4567, "R3 4bpp byte big");
        set_cfg(3'd2, 0, 1, 0, 1);
        push_word(32'h89AB_CDEF, "R4 4bpp msb-first");
        set_cfg(3'd3, 0, 0, 0, 1);
        push_word(32'hDEAD_BEEF, "R2 8bpp"); push_word(32'h0102_0304, "R2 8bpp second word");
        set_cfg(3'd3, 1, 0, 0, 1);
        push_word(32'hDEAD_BEEF, "R3 8bpp byte big");
        set_cfg(3'd3, 0, 1, 1, 1);
        push_word(32'hC0FF_EE11, "R5 R7 8bpp pix order and swap ignored");
        set_cfg(3'd4, 0, 0, 0, 1);
        push_word(32'hF800_07E0, "R6 16bpp widen"); push_word(32'h001F_AAAA, "R6 16bpp widen b");
        set_cfg(3'd4, 1, 0, 0, 1);
        push_word(32'hF800_07E0, "R3 16bpp byte big");
        set_cfg(3'd4, 0, 1, 1, 1);
        push_word(32'hF81F_5A5A, "R5 R7 16bpp swap");
        set_cfg(3'd0, 1, 1, 0, 1);
        req_rand = 1;
        push_word(32'h7E81_3CC3, "R9 1bpp gapped requests");
        push_word(32'h55AA_0FF0, "R9 1bpp gapped second word");
        set_cfg(3'd4, 0, 0, 0, 1);
        push_word(32'h1234_ABCD, "R6 16bpp gapped");
        wait (exp_q.size() == 0);
        req_rand = 0;
        repeat (3) @(negedge clk);
        // R8: power on shows the last pixel; power off clears it
        check(pix_data === last_exp, "R8 power on holds last pixel", {8'h0, pix_data}, {8'h0, last_exp});
        pwr_en = 0;
        repeat (2) @(negedge clk);
        check(pix_data == 0, "R8 power off clears output", {8'h0, pix_data}, 0);
        set_cfg(3'd4, 0, 0, 1, 0);
        push_word(32'hFFFF_F81F, "R8 stream while powered off");
        set_cfg(3'd3, 0, 0, 0, 1);
        // R9: empty FIFO with requests high emits nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(pix_valid == 0, "R9 stall on empty FIFO", {31'h0, pix_valid}, 0);
        end
        req_off = 1;
        push_word(32'h4433_2211, "R9 released request");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(pix_valid == 0, "R9 no request no pixel", {31'h0, pix_valid}, 0);
        end
        req_off = 0;
        wait (exp_q.size() == 0 && fq.size() == 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all pixels emitted", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule